// File: doc/BRIEF.md
# Strobe-Captured Word Serializer

This block turns a wide parallel word into a single-bit serial stream that travels with its own bit clock. A word of 22 data bits and 2 sideband bits is taken in on the rising edge of a strobe. It is then sent as a 26-slot frame: a two-slot start marker, then the 24 payload bits, least significant first. Every slot is paced by a bit-rate tick that the surrounding logic derives from the reference clock. When the strobe runs slower than the frame rate, the slots between frames carry zeros. A half-rate mode uses only every second tick, for systems whose reference is fast compared with the strobe.

The word input has no valid/ready handshake, because the strobe cannot be stalled. There is no back-pressure. A word that arrives while another is shifting waits in a single pending slot and follows the current frame with no gap. A further strobe edge while that slot is still occupied is dropped, and it raises a sticky overrun flag. While the block is disabled, the serial output enable is low, the line reads zero, all state is cleared and strobe edges are ignored.

Top module: `word_serializer`

## Requirements
- R1: While reset is held, and afterwards with the block disabled, ser_data, ser_clk, ser_oe and overrun are 0 and idle is 1.
- R2: A word is captured only in the cycle where strobe goes from 0 to 1. Holding strobe high, or changing the word while it is held, produces no further frame.
- R3: A frame is 26 slots: a marker 1, then a marker 0, then word_data bit 0 through bit 21, then word_side bit 0 and bit 1. When the line is empty, the marker 1 appears in the second slot after the cycle in which the strobe edge is seen.
- R4: Every slot that carries no frame bit sends 0.
- R5: ser_clk toggles once per slot, and ser_data changes only together with a ser_clk toggle. In full-rate mode (half_rate=0), each bit_tick is one slot.
- R6: With half_rate=1, one slot occurs per two bit_tick pulses, and frames keep the R3 format.
- R7: Without bit_tick, ser_data and ser_clk hold their values.
- R8: A word captured while a frame is shifting is sent in the slot right after that frame's last bit.
- R9: A strobe edge that finds the pending slot occupied sets overrun, and its word is never sent. overrun stays 1 until the block is disabled or reset.
- R10: When enable is 0, from the next cycle on, ser_oe, ser_data, ser_clk and overrun are 0 and idle is 1. The pending word and the frame in progress are discarded, and strobe edges seen while disabled are never sent.
- R11: idle is 0 from the cycle after a strobe edge is captured. It returns to 1 once no word is pending and no frame bits remain to be sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | 1 = transmit, 0 = released and cleared |
| half_rate | input | 1 | 1 = one slot per two ticks |
| bit_tick | input | 1 | Bit-rate enable derived from the reference |
| strobe | input | 1 | Word capture strobe (rising edge) |
| word_data | input | 22 | Data bits of the word |
| word_side | input | 2 | Sideband bits of the word |
| ser_data | output | 1 | Serial data |
| ser_clk | output | 1 | Serial bit clock, edge-aligned with ser_data |
| ser_oe | output | 1 | Serial output enable (0 = released) |
| idle | output | 1 | No word pending and no bits left to send |
| overrun | output | 1 | Sticky: a word was dropped |

## Verification
A strobe edge driven before a given clock edge shows up on idle and overrun after one register stage, so the bench samples those flags at the following falling edge. The marker reaches the line one slot later than that. Serial output moves only on slot edges, so the bench samples every falling edge and records ser_data whenever ser_clk has toggled. It then checks frames by their slot positions (marker position, back-to-back start at marker plus 26, zero fill after) rather than by absolute time. Disable effects take one cycle, and the bench checks them two falling edges after dropping enable.

// File: rtl/wser_pkg.sv
package wser_pkg;
  parameter int DATA_W_DEF = 22;
  parameter int SIDE_W_DEF = 2;
  parameter int MARK_W_DEF = 2;
endpackage

// File: rtl/wser_strobe_capture.sv
// Rising-edge detection on the strobe plus a single pending-word slot.
module wser_strobe_capture #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         strobe,
  input  logic [W-1:0] word_i,
  input  logic         pop,
  output logic [W-1:0] hold_word,
  output logic         hold_full,
  output logic         ovr
);
  logic strb_q;
  logic rise;

  assign rise = en & strobe & ~strb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q    <= 1'b0;
      hold_word <= '0;
      hold_full <= 1'b0;
      ovr       <= 1'b0;
    end else if (!en) begin
      strb_q    <= 1'b0;
      hold_word <= '0;
      hold_full <= 1'b0;
      ovr       <= 1'b0;
    end else begin
      strb_q <= strobe;
      if (rise) begin
        if (!hold_full || pop) begin
          hold_word <= word_i;
          hold_full <= 1'b1;
        end else begin
          ovr <= 1'b1;
        end
      end else if (pop) begin
        hold_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wser_slot_timer.sv
// Turns the bit-rate tick into slot pulses, halving the rate when asked.
module wser_slot_timer (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic half,
  input  logic bit_tick,
  output logic slot
);
  logic div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            div_q <= 1'b0;
    else if (!en || !half) div_q <= 1'b0;
    else if (bit_tick)     div_q <= ~div_q;
  end

  assign slot = en & bit_tick & (~half | div_q);
endmodule

// File: rtl/wser_frame_shifter.sv
// Emits marker + payload LSB first, one bit per slot; zero fill otherwise.
module wser_frame_shifter #(
  parameter int PAY_W  = 24,
  parameter int MARK_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             slot,
  input  logic             word_ready,
  input  logic [PAY_W-1:0] word_in,
  output logic             pop,
  output logic             busy,
  output logic             sd,
  output logic             sc
);
  localparam int FRAME_W = PAY_W + MARK_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [MARK_W-1:0] MARKER = MARK_W'(1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] frame;

  assign frame = {word_in, MARKER};
  assign busy  = (cnt_q != '0);
  assign pop   = slot & ~busy & word_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sd    <= 1'b0;
      sc    <= 1'b0;
    end else if (!en) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sd    <= 1'b0;
      sc    <= 1'b0;
    end else if (slot) begin
      sc <= ~sc;
      if (busy) begin
        sd    <= sh_q[0];
        sh_q  <= sh_q >> 1;
        cnt_q <= cnt_q - 1'b1;
      end else if (word_ready) begin
        sd    <= frame[0];
        sh_q  <= frame >> 1;
        cnt_q <= CNT_W'(FRAME_W - 1);
      end else begin
        sd <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/word_serializer.sv
module word_serializer #(
  parameter int DATA_W = wser_pkg::DATA_W_DEF,
  parameter int SIDE_W = wser_pkg::SIDE_W_DEF,
  parameter int MARK_W = wser_pkg::MARK_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              half_rate,
  input  logic              bit_tick,
  input  logic              strobe,
  input  logic [DATA_W-1:0] word_data,
  input  logic [SIDE_W-1:0] word_side,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_oe,
  output logic              idle,
  output logic              overrun
);
  localparam int PAY_W = DATA_W + SIDE_W;

  logic [PAY_W-1:0] hold_word;
  logic             hold_full;
  logic             pop;
  logic             busy;
  logic             slot;

  wser_strobe_capture #(.W(PAY_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .en(enable), .strobe(strobe),
    .word_i({word_side, word_data}), .pop(pop),
    .hold_word(hold_word), .hold_full(hold_full), .ovr(overrun)
  );

  wser_slot_timer u_tmr (
    .clk(clk), .rst_n(rst_n), .en(enable), .half(half_rate),
    .bit_tick(bit_tick), .slot(slot)
  );

  wser_frame_shifter #(.PAY_W(PAY_W), .MARK_W(MARK_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .en(enable), .slot(slot),
    .word_ready(hold_full), .word_in(hold_word), .pop(pop),
    .busy(busy), .sd(ser_data), .sc(ser_clk)
  );

  assign ser_oe = enable;
  assign idle   = ~busy & ~hold_full;
endmodule

// File: rtl/word_serializer_chk.sv
module word_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic half_rate,
  input logic bit_tick,
  input logic ser_data,
  input logic ser_clk,
  input logic idle,
  input logic overrun
);
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!ser_data && !ser_clk && idle && !overrun));

  a_r5_clk_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && (ser_clk != $past(ser_clk))) |-> $past(bit_tick));

  a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !$past(bit_tick)) |-> ($stable(ser_data) && $stable(ser_clk)));

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && enable) |=> overrun);

  a_r4_fill_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(idle) && $past(bit_tick) && !$past(half_rate) && $past(enable)) |-> !ser_data);
endmodule

bind word_serializer word_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .half_rate(half_rate),
  .bit_tick(bit_tick), .ser_data(ser_data), .ser_clk(ser_clk),
  .idle(idle), .overrun(overrun)
);

// File: tb/test_word_serializer.sv
module test_word_serializer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, enable, half_rate, bit_tick, strobe;
  logic [21:0] word_data;
  logic [1:0]  word_side;
  logic        ser_data, ser_clk, ser_oe, idle, overrun;

  word_serializer i_word_serializer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .half_rate(half_rate),
    .bit_tick(bit_tick), .strobe(strobe), .word_data(word_data),
    .word_side(word_side), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_oe(ser_oe), .idle(idle), .overrun(overrun)
  );

  int   checks = 0;
  int   fails = 0;
  bit   done = 0;
  bit   bits [0:255];
  int   nb;
  int   misalign;
  logic prev_clk, prev_data;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sample_one();
    @(negedge clk);
    if (ser_clk !== prev_clk) begin
      if (nb < 256) bits[nb] = ser_data;
      nb++;
    end else if (ser_data !== prev_data) begin
      misalign++;
    end
    prev_clk  = ser_clk;
    prev_data = ser_data;
  endtask

  task automatic start_capture();
    nb = 0;
    prev_clk  = ser_clk;
    prev_data = ser_data;
  endtask

  task automatic collect(int n);
    for (int i = 0; i < n; i++) sample_one();
  endtask

  task automatic pulse_strobe(logic [21:0] d, logic [1:0] s);
    word_data = d;
    word_side = s;
    strobe = 1'b1;
    sample_one();
    strobe = 1'b0;
  endtask

  task automatic check_frame(int from, logic [21:0] d, logic [1:0] s, string req, output int pos);
    logic [25:0] exp_fr;
    logic [25:0] got;
    exp_fr = {s, d, 1'b0, 1'b1};
    got = '0;
    pos = -1;
    for (int i = from; i < nb && i < 256; i++)
      if (bits[i] && pos < 0) pos = i;
    chk(req, "marker found", int'(pos >= 0), 1);
    if (pos >= 0) begin
      for (int k = 0; k < 26; k++)
        if (pos + k < nb && pos + k < 256) got[k] = bits[pos + k];
      chk(req, "frame bits", int'(got), int'(exp_fr));
    end
  endtask

  task automatic check_fill(int from, string req);
    int ones = 0;
    for (int i = from; i < nb && i < 256; i++) if (bits[i]) ones++;
    chk(req, "ones in fill slots", ones, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b0; half_rate = 1'b0; bit_tick = 1'b1;
    strobe = 1'b0; word_data = '0; word_side = '0;
    repeat (3) @(negedge clk);
    chk("R1", "ser_data in reset", int'(ser_data), 0);
    chk("R1", "ser_clk in reset", int'(ser_clk), 0);
    chk("R1", "idle in reset", int'(idle), 1);
    chk("R1", "overrun in reset", int'(overrun), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ser_oe while disabled", int'(ser_oe), 0);
    chk("R1", "idle while disabled", int'(idle), 1);
    enable = 1'b1;
    @(negedge clk);
    chk("R1", "ser_oe once enabled", int'(ser_oe), 1);
  endtask

  task automatic t_single();
    int pos;
    collect(4);
    start_capture();
    misalign = 0;
    pulse_strobe(22'h2A5C3B, 2'b10);
    chk("R11", "idle after capture", int'(idle), 0);
    collect(40);
    check_frame(0, 22'h2A5C3B, 2'b10, "R3", pos);
    chk("R3", "marker slot index", pos, 1);
    check_fill(pos + 26, "R4");
    chk("R11", "idle after frame", int'(idle), 1);
    chk("R5", "data moves only with clock", misalign, 0);
  endtask

  task automatic t_hold();
    int pos;
    start_capture();
    word_data = 22'h155AA3; word_side = 2'b01;
    strobe = 1'b1;
    for (int i = 0; i < 50; i++) begin
      sample_one();
      if (i == 5) begin word_data = 22'h3FFFFF; word_side = 2'b11; end
    end
    strobe = 1'b0;
    collect(20);
    check_frame(0, 22'h155AA3, 2'b01, "R2", pos);
    check_fill(pos + 26, "R2");
  endtask

  task automatic t_b2b();
    int p1, p2;
    start_capture();
    pulse_strobe(22'h0F0F0F, 2'b11);
    collect(3);
    pulse_strobe(22'h30C0C1, 2'b01);
    chk("R9", "overrun with one pending", int'(overrun), 0);
    collect(3);
    pulse_strobe(22'h3FFFFF, 2'b11);
    chk("R9", "overrun after extra edge", int'(overrun), 1);
    collect(70);
    check_frame(0, 22'h0F0F0F, 2'b11, "R8", p1);
    check_frame(p1 + 26, 22'h30C0C1, 2'b01, "R8", p2);
    chk("R8", "second frame follows at once", p2, p1 + 26);
    check_fill(p2 + 26, "R9");
    collect(5);
    chk("R9", "overrun stays set", int'(overrun), 1);
  endtask

  task automatic t_disable();
    enable = 1'b0;
    collect(2);
    chk("R10", "ser_oe", int'(ser_oe), 0);
    chk("R10", "ser_data", int'(ser_data), 0);
    chk("R10", "ser_clk", int'(ser_clk), 0);
    chk("R10", "idle", int'(idle), 1);
    chk("R10", "overrun cleared", int'(overrun), 0);
    pulse_strobe(22'h2AAAAA, 2'b11);
    collect(4);
    enable = 1'b1;
    start_capture();
    collect(40);
    check_fill(0, "R10");
    chk("R10", "idle after re-enable", int'(idle), 1);
  endtask

  task automatic t_rate();
    int pos;
    start_capture();
    collect(20);
    chk("R5", "toggles in 20 full-rate ticks", nb, 20);
    half_rate = 1'b1;
    collect(2);
    start_capture();
    collect(20);
    chk("R6", "toggles in 20 half-rate ticks", nb, 10);
    start_capture();
    pulse_strobe(22'h1234AB, 2'b10);
    collect(70);
    check_frame(0, 22'h1234AB, 2'b10, "R6", pos);
    half_rate = 1'b0;
    collect(2);
    start_capture();
    for (int i = 0; i < 30; i++) begin
      bit_tick = (i % 3 == 0);
      sample_one();
    end
    chk("R7", "toggles with sparse ticks", nb, 10);
    bit_tick = 1'b0;
    start_capture();
    collect(10);
    chk("R7", "toggles without ticks", nb, 0);
    bit_tick = 1'b1;
  endtask

  initial begin
    t_reset();
    t_single();
    t_hold();
    t_b2b();
    t_disable();
    t_rate();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule